// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block lets a CPU program its own on-chip flash. Software writes a five-bit command word into a control register. A legal word arms a short acceptance window. The next store-to-program-memory strobe inside that window carries out the armed command. A bare enable fills one word of the temporary page buffer. Enable plus the erase bit erases a page. Enable plus the page-write bit programs a page from the buffer. Enable plus the lock-read bit lets a following load strobe fetch lock or fuse bits instead of code. Enable plus the read-while-write re-enable bit is accepted and is retired by the next store strobe.

A 24-bit byte pointer supplies the address. Bit 0 is the byte select. The next log2(page size) bits pick a word within a page, and the bits above those pick the page. Erase and page-write requests go to the flash as one-cycle pulses. The controller then stays busy until the flash reports done. While it is busy, the command bits stay visible. If the target page lies in the no-read-while-write region, the CPU is halted for the whole operation. Every output is registered and follows its cause by one clock.

Top module: `spm_cmd_ctrl`

## Requirements
- R1: While reset is high and in the cycle after reset, `cmd_state` is 0 and every request, halt and read output is 0.
- R2: A control write arms a command only when its value is one of 5'b00001 (fill), 5'b00011 (erase), 5'b00101 (page write), 5'b01001 (lock read) or 5'b10001 (re-enable). The armed value then shows on `cmd_state` in the next cycle. Any other value leaves `cmd_state` and all outputs unchanged.
- R3: A store strobe is accepted in any of the four cycles that follow the arming write. If none arrives, `cmd_state` returns to 0 after the fourth of those cycles, and later strobes have no effect.
- R4: A strobe on an armed fill gives a one-cycle `buf_we` in the next cycle. `buf_word` is `zptr[7:1]`, `buf_data` is `wdata`, and `zptr[0]` has no effect. In that same cycle `cmd_state` reads 0.
- R5: A strobe on an armed erase gives a one-cycle `erase_req` in the next cycle, with `page_addr` equal to `zptr[23:8]`.
- R6: A strobe on an armed page write gives a one-cycle `program_req` in the next cycle, with `page_addr` equal to `zptr[23:8]`.
- R7: After an erase or page-write request, `cmd_state` keeps its enable and operation bits until the cycle in which `flash_done` is high, and reads 0 in the cycle after. Control writes and store strobes in the meantime have no effect.
- R8: With lock read armed, a load strobe in any of the first three cycles after the arming write gives a one-cycle `lockfuse_rd` in the next cycle, with `lockfuse_sel` equal to `zptr[0]`. A load strobe in the fourth cycle gives nothing, and a load strobe under any other command gives nothing.
- R9: `cpu_halt` is high from the request cycle through the cycle of `flash_done` exactly when the page address is at least `NRWW_FIRST_PAGE` (480 by default). Otherwise it stays low.
- R10: A store strobe with no armed command, including one in the same cycle as the arming write, has no effect. A strobe on an armed re-enable retires it with no request pulse.
- R11: A legal control write while a command is armed and no strobe is present replaces the command and restarts the four-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Command bits written to the control register |
| spm_stb | input | 1 | Store-to-program-memory strobe |
| lpm_stb | input | 1 | Load-from-program-memory strobe |
| zptr | input | 24 | Byte address pointer |
| wdata | input | 16 | Data word for a buffer fill |
| flash_done | input | 1 | Flash finished the erase or page write |
| cmd_state | output | 5 | Current command bits of the control register |
| buf_we | output | 1 | Temporary buffer write pulse |
| buf_word | output | 7 | Word index within the page buffer |
| buf_data | output | 16 | Word written into the buffer |
| erase_req | output | 1 | Page erase request pulse |
| program_req | output | 1 | Page write request pulse |
| page_addr | output | 16 | Page targeted by erase or write |
| lockfuse_rd | output | 1 | Load returns lock/fuse bits instead of code |
| lockfuse_sel | output | 1 | 0 selects fuse bits, 1 selects lock bits (pointer bit 0) |
| cpu_halt | output | 1 | Stall the CPU while the no-read-while-write region is busy |

## Verification
If the window counter or command register is off, the fault shows at once on `cmd_state`: it clears one cycle early or late around the fourth cycle after a write, or it shows a value outside the five legal patterns. A strobe in the boundary cycle then gives a request pulse where none should appear, or drops one that should. A busy state that is lost or stuck shows as `cmd_state` clearing before `flash_done`, or never clearing, and `cpu_halt` tracks the same error. Address slicing faults show in the cycle of the pulse, as a wrong `buf_word` or `page_addr`.

// File: rtl/spm_pkg.sv
package spm_pkg;

    // bit positions in the command word
    localparam int CMD_W   = 5;
    localparam int B_EN    = 0;
    localparam int B_ERASE = 1;
    localparam int B_PROG  = 2;
    localparam int B_LOCK  = 3;
    localparam int B_RWW   = 4;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_FILL,
        OP_ERASE,
        OP_PROG,
        OP_LOCKRD,
        OP_RWWEN
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_BUSY
    } st_e;

    typedef struct packed {
        st_e st;
        op_e op;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{st: ST_IDLE, op: OP_NONE};

    function automatic op_e decode_op(input logic [CMD_W-1:0] v);
        op_e r;
        r = OP_NONE;
        if (v[B_EN]) begin
            unique case (v & ~(CMD_W'(1) << B_EN))
                5'b00000: r = OP_FILL;
                5'b00010: r = OP_ERASE;
                5'b00100: r = OP_PROG;
                5'b01000: r = OP_LOCKRD;
                5'b10000: r = OP_RWWEN;
                default:  r = OP_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [CMD_W-1:0] op_bits(input op_e op);
        logic [CMD_W-1:0] b;
        b = '0;
        if (op != OP_NONE) b[B_EN] = 1'b1;
        unique case (op)
            OP_ERASE:  b[B_ERASE] = 1'b1;
            OP_PROG:   b[B_PROG]  = 1'b1;
            OP_LOCKRD: b[B_LOCK]  = 1'b1;
            OP_RWWEN:  b[B_RWW]   = 1'b1;
            default:   ;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spm_cmd_decode.sv
module spm_cmd_decode
    import spm_pkg::*;
(
    input  logic             wr_en,
    input  logic [CMD_W-1:0] bits,
    output op_e              op,
    output logic             legal
);
    always_comb begin
        op    = decode_op(bits);
        legal = wr_en && (op != OP_NONE);
    end
endmodule

// File: rtl/spm_window_timer.sv
module spm_window_timer #(
    parameter int WINDOW     = 4,
    parameter int LPM_WINDOW = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic expire,
    output logic lpm_open
);
    localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run && !expire) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        expire   = (int'(cnt) == WINDOW - 1);
        lpm_open = (int'(cnt) < LPM_WINDOW);
    end
endmodule

// File: rtl/spm_addr_split.sv
module spm_addr_split #(
    parameter int ADDR_W          = 24,
    parameter int WORD_W          = 7,
    parameter int PAGE_W          = 16,
    parameter int NRWW_FIRST_PAGE = 480
) (
    input  logic [ADDR_W-1:0] ptr,
    output logic [WORD_W-1:0] word,
    output logic [PAGE_W-1:0] page,
    output logic              byte_sel,
    output logic              in_nrww
);
    assign byte_sel = ptr[0];
    assign word     = ptr[WORD_W:1];
    assign page     = ptr[ADDR_W-1:WORD_W+1];

    generate
        if (NRWW_FIRST_PAGE <= 0) begin : g_all_nrww
            assign in_nrww = 1'b1;
        end else begin : g_cmp_nrww
            localparam logic [PAGE_W-1:0] FIRST = PAGE_W'(NRWW_FIRST_PAGE);
            assign in_nrww = (page >= FIRST);
        end
    endgenerate
endmodule

// File: rtl/spm_cmd_ctrl.sv
module spm_cmd_ctrl
    import spm_pkg::*;
#(
    parameter int ADDR_W          = 24,
    parameter int DATA_W          = 16,
    parameter int PAGE_WORDS      = 128,
    parameter int WINDOW          = 4,
    parameter int LPM_WINDOW      = 3,
    parameter int NRWW_FIRST_PAGE = 480,
    localparam int WORD_W         = $clog2(PAGE_WORDS),
    localparam int PAGE_W         = ADDR_W - 1 - WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [CMD_W-1:0]  ctl_wdata,
    input  logic              spm_stb,
    input  logic              lpm_stb,
    input  logic [ADDR_W-1:0] zptr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flash_done,
    output logic [CMD_W-1:0]  cmd_state,
    output logic              buf_we,
    output logic [WORD_W-1:0] buf_word,
    output logic [DATA_W-1:0] buf_data,
    output logic              erase_req,
    output logic              program_req,
    output logic [PAGE_W-1:0] page_addr,
    output logic              lockfuse_rd,
    output logic              lockfuse_sel,
    output logic              cpu_halt
);
    op_e               dec_op;
    logic              dec_legal;
    logic [WORD_W-1:0] z_word;
    logic [PAGE_W-1:0] z_page;
    logic              z_byte;
    logic              z_nrww;
    logic              win_expire;
    logic              lpm_open;
    logic              arm_evt;
    logic              nrww_q;
    ctrl_t             cur;

    spm_cmd_decode u_dec (
        .wr_en (ctl_wr),
        .bits  (ctl_wdata),
        .op    (dec_op),
        .legal (dec_legal)
    );

    spm_addr_split #(
        .ADDR_W          (ADDR_W),
        .WORD_W          (WORD_W),
        .PAGE_W          (PAGE_W),
        .NRWW_FIRST_PAGE (NRWW_FIRST_PAGE)
    ) u_split (
        .ptr      (zptr),
        .word     (z_word),
        .page     (z_page),
        .byte_sel (z_byte),
        .in_nrww  (z_nrww)
    );

    // a legal write arms from idle, or re-arms when no strobe competes
    assign arm_evt = dec_legal &&
                     ((cur.st == ST_IDLE) || ((cur.st == ST_ARMED) && !spm_stb));

    spm_window_timer #(
        .WINDOW     (WINDOW),
        .LPM_WINDOW (LPM_WINDOW)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .restart  (arm_evt),
        .run      (cur.st == ST_ARMED),
        .expire   (win_expire),
        .lpm_open (lpm_open)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur          <= CTRL_IDLE;
            buf_we       <= 1'b0;
            buf_word     <= '0;
            buf_data     <= '0;
            erase_req    <= 1'b0;
            program_req  <= 1'b0;
            page_addr    <= '0;
            lockfuse_rd  <= 1'b0;
            lockfuse_sel <= 1'b0;
            nrww_q       <= 1'b0;
        end else begin
            buf_we      <= 1'b0;
            erase_req   <= 1'b0;
            program_req <= 1'b0;
            lockfuse_rd <= 1'b0;
            unique case (cur.st)
                ST_IDLE: begin
                    if (arm_evt) begin
                        cur.st <= ST_ARMED;
                        cur.op <= dec_op;
                    end
                end
                ST_ARMED: begin
                    if (lpm_stb && lpm_open && (cur.op == OP_LOCKRD)) begin
                        lockfuse_rd  <= 1'b1;
                        lockfuse_sel <= z_byte;
                    end
                    if (spm_stb) begin
                        unique case (cur.op)
                            OP_FILL: begin
                                buf_we   <= 1'b1;
                                buf_word <= z_word;
                                buf_data <= wdata;
                                cur      <= CTRL_IDLE;
                            end
                            OP_ERASE: begin
                                erase_req <= 1'b1;
                                page_addr <= z_page;
                                nrww_q    <= z_nrww;
                                cur.st    <= ST_BUSY;
                            end
                            OP_PROG: begin
                                program_req <= 1'b1;
                                page_addr   <= z_page;
                                nrww_q      <= z_nrww;
                                cur.st      <= ST_BUSY;
                            end
                            default: cur <= CTRL_IDLE;
                        endcase
                    end else if (arm_evt) begin
                        cur.op <= dec_op;
                    end else if (win_expire) begin
                        cur <= CTRL_IDLE;
                    end
                end
                ST_BUSY: begin
                    if (flash_done) begin
                        cur    <= CTRL_IDLE;
                        nrww_q <= 1'b0;
                    end
                end
                default: cur <= CTRL_IDLE;
            endcase
        end
    end

    assign cmd_state = op_bits(cur.op);
    assign cpu_halt  = (cur.st == ST_BUSY) && nrww_q;

endmodule

// File: rtl/spm_cmd_ctrl_chk.sv
module spm_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic       flash_done,
    input logic [4:0] cmd_state,
    input logic       buf_we,
    input logic       erase_req,
    input logic       program_req,
    input logic       lockfuse_rd,
    input logic       cpu_halt
);
    // R2: only legal patterns ever appear in the command register
    p_legal_state_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_state inside {5'b00000, 5'b00001, 5'b00011, 5'b00101, 5'b01001, 5'b10001});

    // R2: arming needs a control write in the cycle before
    p_arm_needs_write_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_state[0]) |-> $past(ctl_wr));

    // R4: a buffer fill retires the command
    p_fill_retires_r4: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (cmd_state == 5'b00000));

    // R5: erase request lasts one cycle and keeps the erase bits
    p_erase_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        erase_req |=> !erase_req);
    p_erase_bits_r5: assert property (@(posedge clk) disable iff (rst)
        erase_req |-> (cmd_state == 5'b00011));

    // R6: page write request lasts one cycle and keeps its bits
    p_prog_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        program_req |=> !program_req);
    p_prog_bits_r6: assert property (@(posedge clk) disable iff (rst)
        program_req |-> (cmd_state == 5'b00101));

    // R7: the busy bits do not vanish without a done
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_halt && !flash_done) |=> (cmd_state == $past(cmd_state)));

    // R8: lock/fuse read only under an armed lock-read command
    p_lock_src_r8: assert property (@(posedge clk) disable iff (rst)
        lockfuse_rd |-> ($past(cmd_state) == 5'b01001));

    // R9: halt only while erasing or writing, held until done
    p_halt_busy_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_halt |-> (cmd_state == 5'b00011 || cmd_state == 5'b00101));
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_halt && !flash_done) |=> cpu_halt);

    // R10: at most one action per cycle
    p_one_action_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({buf_we, erase_req, program_req, lockfuse_rd}));
endmodule

bind spm_cmd_ctrl spm_cmd_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .flash_done  (flash_done),
    .cmd_state   (cmd_state),
    .buf_we      (buf_we),
    .erase_req   (erase_req),
    .program_req (program_req),
    .lockfuse_rd (lockfuse_rd),
    .cpu_halt    (cpu_halt)
);

// File: tb/spm_cmd_ctrl_test.sv
module spm_cmd_ctrl_test;

    typedef enum int {K_NONE, K_WE, K_ER, K_PW, K_RD} kind_e;

    typedef struct {
        logic [4:0]  st;
        kind_e       kind;
        logic [6:0]  word;
        logic [15:0] data;
        logic [15:0] page;
        logic        sel;
        logic        halt;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [4:0]  ctl_wdata = '0;
    logic        spm_stb = 1'b0;
    logic        lpm_stb = 1'b0;
    logic [23:0] zptr = '0;
    logic [15:0] wdata = '0;
    logic        flash_done = 1'b0;
    logic [4:0]  cmd_state;
    logic        buf_we;
    logic [6:0]  buf_word;
    logic [15:0] buf_data;
    logic        erase_req;
    logic        program_req;
    logic [15:0] page_addr;
    logic        lockfuse_rd;
    logic        lockfuse_sel;
    logic        cpu_halt;

    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    spm_cmd_ctrl uut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .spm_stb(spm_stb), .lpm_stb(lpm_stb), .zptr(zptr), .wdata(wdata),
        .flash_done(flash_done), .cmd_state(cmd_state), .buf_we(buf_we),
        .buf_word(buf_word), .buf_data(buf_data), .erase_req(erase_req),
        .program_req(program_req), .page_addr(page_addr),
        .lockfuse_rd(lockfuse_rd), .lockfuse_sel(lockfuse_sel), .cpu_halt(cpu_halt)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t ex(input logic [4:0] st, input kind_e k,
                                input logic [6:0] w, input logic [15:0] d,
                                input logic [15:0] p, input logic s,
                                input logic h, input string tag);
        exp_t e;
        e.st = st; e.kind = k; e.word = w; e.data = d;
        e.page = p; e.sel = s; e.halt = h; e.tag = tag;
        return e;
    endfunction

    function automatic exp_t quiet(input logic [4:0] st, input logic h, input string tag);
        return ex(st, K_NONE, '0, '0, '0, 1'b0, h, tag);
    endfunction

    // driver: one cycle of stimulus plus the outputs expected after that edge
    task automatic drive(input logic w, input logic [4:0] wv, input logic s,
                         input logic l, input logic [23:0] z, input logic [15:0] d,
                         input logic dn, input exp_t e);
        @(negedge clk);
        ctl_wr = w; ctl_wdata = wv; spm_stb = s; lpm_stb = l;
        zptr = z; wdata = d; flash_done = dn;
        sb.push_back(e);
    endtask

    task automatic idle(input exp_t e);
        drive(1'b0, 5'b0, 1'b0, 1'b0, 24'h0, 16'h0, 1'b0, e);
    endtask

    task automatic wr(input logic [4:0] v, input exp_t e);
        drive(1'b1, v, 1'b0, 1'b0, 24'h0, 16'h0, 1'b0, e);
    endtask

    task automatic stb(input logic [23:0] z, input logic [15:0] d, input exp_t e);
        drive(1'b0, 5'b0, 1'b1, 1'b0, z, d, 1'b0, e);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "cmd_state", 32'(cmd_state), 32'(e.st));
            chk(e.tag, "buf_we", 32'(buf_we), 32'(e.kind == K_WE));
            chk(e.tag, "erase_req", 32'(erase_req), 32'(e.kind == K_ER));
            chk(e.tag, "program_req", 32'(program_req), 32'(e.kind == K_PW));
            chk(e.tag, "lockfuse_rd", 32'(lockfuse_rd), 32'(e.kind == K_RD));
            chk(e.tag, "cpu_halt", 32'(cpu_halt), 32'(e.halt));
            if (e.kind == K_WE) begin
                chk(e.tag, "buf_word", 32'(buf_word), 32'(e.word));
                chk(e.tag, "buf_data", 32'(buf_data), 32'(e.data));
            end
            if (e.kind == K_ER || e.kind == K_PW)
                chk(e.tag, "page_addr", 32'(page_addr), 32'(e.page));
            if (e.kind == K_RD)
                chk(e.tag, "lockfuse_sel", 32'(lockfuse_sel), 32'(e.sel));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "cmd_state in reset", 32'(cmd_state), 32'h0);
        chk("R1", "pulses in reset", 32'({buf_we, erase_req, program_req, lockfuse_rd, cpu_halt}), 32'h0);
        rst = 1'b0;
        idle(quiet(5'b00000, 1'b0, "R1"));

        // R4: fill on the first cycle, pointer bit 0 set but ignored
        wr(5'b00001, quiet(5'b00001, 1'b0, "R2"));
        stb(24'h001235, 16'hA5C3, ex(5'b00000, K_WE, 7'h1A, 16'hA5C3, '0, 1'b0, 1'b0, "R4"));
        idle(quiet(5'b00000, 1'b0, "R4"));

        // R3: fill on the fourth cycle is still accepted
        wr(5'b00001, quiet(5'b00001, 1'b0, "R3"));
        idle(quiet(5'b00001, 1'b0, "R3"));
        idle(quiet(5'b00001, 1'b0, "R3"));
        idle(quiet(5'b00001, 1'b0, "R3"));
        stb(24'h0000FE, 16'h1234, ex(5'b00000, K_WE, 7'h7F, 16'h1234, '0, 1'b0, 1'b0, "R3"));

        // R3: window runs out, late strobe ignored
        wr(5'b00001, quiet(5'b00001, 1'b0, "R3"));
        idle(quiet(5'b00001, 1'b0, "R3"));
        idle(quiet(5'b00001, 1'b0, "R3"));
        idle(quiet(5'b00001, 1'b0, "R3"));
        idle(quiet(5'b00000, 1'b0, "R3"));
        stb(24'h000010, 16'hBEEF, quiet(5'b00000, 1'b0, "R3"));

        // R2: illegal patterns do nothing; R10 strobe unarmed
        wr(5'b00111, quiet(5'b00000, 1'b0, "R2"));
        wr(5'b10000, quiet(5'b00000, 1'b0, "R2"));
        wr(5'b00010, quiet(5'b00000, 1'b0, "R2"));
        wr(5'b11001, quiet(5'b00000, 1'b0, "R2"));
        stb(24'h000020, 16'h5555, quiet(5'b00000, 1'b0, "R10"));

        // R5/R7/R9: erase outside the halt region, busy ignores input
        wr(5'b00011, quiet(5'b00011, 1'b0, "R2"));
        stb(24'h012345, 16'hFFFF, ex(5'b00011, K_ER, '0, '0, 16'h0123, 1'b0, 1'b0, "R5"));
        idle(quiet(5'b00011, 1'b0, "R7"));
        wr(5'b00001, quiet(5'b00011, 1'b0, "R7"));
        stb(24'h000000, 16'h0000, quiet(5'b00011, 1'b0, "R7"));
        idle(quiet(5'b00011, 1'b0, "R7"));
        drive(1'b0, 5'b0, 1'b0, 1'b0, 24'h0, 16'h0, 1'b1, quiet(5'b00000, 1'b0, "R7"));
        idle(quiet(5'b00000, 1'b0, "R7"));

        // R6/R9: page write inside the halt region
        wr(5'b00101, quiet(5'b00101, 1'b0, "R2"));
        stb(24'h01E042, 16'h0F0F, ex(5'b00101, K_PW, '0, '0, 16'h01E0, 1'b0, 1'b1, "R6"));
        idle(quiet(5'b00101, 1'b1, "R9"));
        idle(quiet(5'b00101, 1'b1, "R9"));
        drive(1'b0, 5'b0, 1'b0, 1'b0, 24'h0, 16'h0, 1'b1, quiet(5'b00000, 1'b0, "R9"));
        idle(quiet(5'b00000, 1'b0, "R9"));

        // R8: lock read window of three cycles
        wr(5'b01001, quiet(5'b01001, 1'b0, "R2"));
        idle(quiet(5'b01001, 1'b0, "R8"));
        drive(1'b0, 5'b0, 1'b0, 1'b1, 24'h000001, 16'h0, 1'b0,
              ex(5'b01001, K_RD, '0, '0, '0, 1'b1, 1'b0, "R8"));
        drive(1'b0, 5'b0, 1'b0, 1'b1, 24'h000000, 16'h0, 1'b0,
              ex(5'b01001, K_RD, '0, '0, '0, 1'b0, 1'b0, "R8"));
        drive(1'b0, 5'b0, 1'b0, 1'b1, 24'h000001, 16'h0, 1'b0, quiet(5'b00000, 1'b0, "R8"));

        // R8: load strobe under fill gives no lock read
        wr(5'b00001, quiet(5'b00001, 1'b0, "R8"));
        drive(1'b0, 5'b0, 1'b0, 1'b1, 24'h000001, 16'h0, 1'b0, quiet(5'b00001, 1'b0, "R8"));
        stb(24'h000004, 16'hCAFE, ex(5'b00000, K_WE, 7'h02, 16'hCAFE, '0, 1'b0, 1'b0, "R4"));

        // R10: re-enable retired silently
        wr(5'b10001, quiet(5'b10001, 1'b0, "R10"));
        stb(24'h000100, 16'h1111, quiet(5'b00000, 1'b0, "R10"));

        // R10: strobe in the same cycle as the arming write
        drive(1'b1, 5'b00001, 1'b1, 1'b0, 24'h000002, 16'h2222, 1'b0, quiet(5'b00001, 1'b0, "R10"));
        idle(quiet(5'b00001, 1'b0, "R10"));
        idle(quiet(5'b00001, 1'b0, "R10"));
        idle(quiet(5'b00001, 1'b0, "R10"));
        idle(quiet(5'b00000, 1'b0, "R10"));

        // R11: re-arm restarts the window
        wr(5'b00001, quiet(5'b00001, 1'b0, "R11"));
        idle(quiet(5'b00001, 1'b0, "R11"));
        idle(quiet(5'b00001, 1'b0, "R11"));
        wr(5'b00011, quiet(5'b00011, 1'b0, "R11"));
        idle(quiet(5'b00011, 1'b0, "R11"));
        idle(quiet(5'b00011, 1'b0, "R11"));
        idle(quiet(5'b00011, 1'b0, "R11"));
        stb(24'h000100, 16'h0, ex(5'b00011, K_ER, '0, '0, 16'h0001, 1'b0, 1'b0, "R11"));
        drive(1'b0, 5'b0, 1'b0, 1'b0, 24'h0, 16'h0, 1'b1, quiet(5'b00000, 1'b0, "R7"));
        idle(quiet(5'b00000, 1'b0, "R7"));

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule